// File: doc/BRIEF.md
# Vector Instruction Field Decoder

This block takes 32-bit instruction words meant for the vector unit of a 32-bit core and splits them into named fields. Three major opcodes are recognised: one shared by the vector arithmetic operations and the configuration-setting instruction, one for vector loads and one for vector stores. Inside the shared opcode the decoder tells configuration apart from arithmetic. For configuration it also tells the immediate form apart from the register form. For stores the field in the destination position is reported as the register holding the data to be stored.

The word and its strobe are sampled on a clock edge, and the decoded bundle appears on registered outputs one cycle later, qualified by an output valid. Exactly one class flag is raised with each valid output: configuration, arithmetic, load, store or illegal. Fields that do not belong to the decoded class read as zero, so a consumer never sees stale bits from another format. Anything the block does not accept is flagged illegal and carries no fields.

Top module: `vinsn_field_decoder`

## Requirements
- R1: `dec_vld_o` equals the value of `insn_vld_i` at the previous rising edge. While `dec_vld_o` is low, every other output is zero, whatever word was presented.
- R2: Opcode 0x57 (bits 6:0) with func3 (bits 14:12) equal to 7 raises `dec_is_cfg_o`. Opcode 0x57 with any other func3 raises `dec_is_arith_o`.
- R3: Configuration with bit 31 clear is the immediate form. It sets `dec_cfg_imm_form_o`=1 and `dec_cfg_imm_o`=bits 30:20, and reports `dec_rs2_o`=0. `dec_vd_o`=bits 11:7, `dec_rs1_o`=bits 19:15, `dec_funct3_o`=7.
- R4: Configuration with bit 31 set is the register form. It sets `dec_cfg_imm_form_o`=0, `dec_cfg_imm_o`=0 and `dec_rs2_o`=bits 24:20. The destination, source and func3 fields are the same as in R3.
- R5: Arithmetic reports `dec_funct6_o`=bits 31:26, `dec_vm_o`=bit 25, `dec_rs2_o`=bits 24:20, `dec_rs1_o`=bits 19:15, `dec_funct3_o`=bits 14:12 and `dec_vd_o`=bits 11:7. The load/store and configuration fields are zero.
- R6: Opcode 0x07 with width code (bits 14:12) 6 is a load. It reports `dec_vd_o`=bits 11:7, rs1, rs2, `dec_funct3_o`=6, `dec_vm_o`=bit 25, `dec_mop_o`=bits 28:26 and `dec_nf_o`=bits 31:29.
- R7: Opcode 0x27 with width code 6 is a store. It reports `dec_vs3_o`=bits 11:7 and `dec_vd_o`=0. The remaining fields are as for a load.
- R8: Any other opcode, or a load or store whose width code is not 6, raises `dec_illegal_o`. All field outputs and the other class flags are then zero.
- R9: After reset all outputs are zero. With `dec_vld_o` high, exactly one of the five class flags is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| insn_i | input | 32 | Instruction word |
| insn_vld_i | input | 1 | Word strobe |
| dec_vld_o | output | 1 | Decoded bundle valid |
| dec_illegal_o | output | 1 | Word not accepted |
| dec_is_cfg_o | output | 1 | Configuration-setting instruction |
| dec_is_arith_o | output | 1 | Vector arithmetic |
| dec_is_load_o | output | 1 | Vector load |
| dec_is_store_o | output | 1 | Vector store |
| dec_vd_o | output | 5 | Destination register |
| dec_vs3_o | output | 5 | Store data register |
| dec_rs1_o | output | 5 | First source specifier |
| dec_rs2_o | output | 5 | Second source specifier |
| dec_funct3_o | output | 3 | func3 / width code |
| dec_funct6_o | output | 6 | Arithmetic func6 |
| dec_vm_o | output | 1 | Mask bit |
| dec_mop_o | output | 3 | Memory-operation mode |
| dec_nf_o | output | 3 | Field count |
| dec_cfg_imm_form_o | output | 1 | Configuration uses immediate |
| dec_cfg_imm_o | output | 11 | Configuration immediate |

## Verification
The bench aims at the split inside opcode 0x57. A decoder that tested func3 loosely would report an arithmetic word with func3 3 or 6 as configuration. One that mixed up the form bit would hand back an immediate built from register bits. It also sends loads and stores whose width code is anything but 6, which a lax decoder would pass as legal. It sends stores with nonzero data-register bits, which a decoder that forgot the store rule would show as a destination. Finally, it drops the strobe with a fully legal word present and runs words back to back. These cases expose stale fields, a latency other than one cycle, and fields that leak across classes.

// File: rtl/vdec_pkg.sv
// Package: shared widths, class encoding and decoded bundle layout for the
// vector instruction field decoder. Assumes a 32-bit instruction word.
package vdec_pkg;
    localparam int ILEN   = 32;
    localparam int OPC_W  = 7;
    localparam int REG_W  = 5;
    localparam int F3_W   = 3;
    localparam int F6_W   = 6;
    localparam int MOP_W  = 3;
    localparam int NF_W   = 3;
    localparam int CIMM_W = 11;
    localparam int NCLASS = 5;

    // Absolute bit positions inside the instruction word
    localparam int POS_RD   = 7;
    localparam int POS_F3   = 12;
    localparam int POS_RS1  = 15;
    localparam int POS_RS2  = 20;
    localparam int POS_VM   = 25;
    localparam int POS_F6   = 26;
    localparam int POS_MOP  = 26;
    localparam int POS_NF   = 29;
    localparam int POS_CIMM = 20;
    localparam int POS_FORM = 31;

    // Class of a decoded word; NONE means no strobe
    typedef enum logic [2:0] {
        VC_NONE    = 3'd0,
        VC_STORE   = 3'd1,
        VC_LOAD    = 3'd2,
        VC_ARITH   = 3'd3,
        VC_CFG     = 3'd4,
        VC_ILLEGAL = 3'd5
    } vclass_e;

    // Decoded bundle; flag order is illegal, cfg, arith, load, store
    typedef struct packed {
        logic [NCLASS-1:0] flags;
        logic [REG_W-1:0]  vd;
        logic [REG_W-1:0]  vs3;
        logic [REG_W-1:0]  rs1;
        logic [REG_W-1:0]  rs2;
        logic [F3_W-1:0]   funct3;
        logic [F6_W-1:0]   funct6;
        logic              vm;
        logic [MOP_W-1:0]  mop;
        logic [NF_W-1:0]   nf;
        logic              imm_form;
        logic [CIMM_W-1:0] imm;
    } vdec_bundle_t;
endpackage

// File: rtl/vdec_classify.sv
// Module: picks the class of a word from its opcode and func3.
// Assumes opcode values and the unit-stride width code come in as parameters.
module vdec_classify
    import vdec_pkg::*;
#(
    parameter logic [OPC_W-1:0] OPC_VARITH = 7'h57,
    parameter logic [OPC_W-1:0] OPC_VLOAD  = 7'h07,
    parameter logic [OPC_W-1:0] OPC_VSTORE = 7'h27,
    parameter logic [F3_W-1:0]  CFG_F3     = 3'd7,
    parameter logic [F3_W-1:0]  UNIT_WIDTH = 3'd6
) (
    input  logic             vld_i,
    input  logic [OPC_W-1:0] opcode_i,
    input  logic [F3_W-1:0]  funct3_i,
    output vclass_e          cls_o
);
    // Class selection: no strobe, then opcode, then func3 / width
    always_comb begin
        if (!vld_i) begin
            cls_o = VC_NONE;
        end else if (opcode_i == OPC_VARITH) begin
            cls_o = (funct3_i == CFG_F3) ? VC_CFG : VC_ARITH;
        end else if (opcode_i == OPC_VLOAD) begin
            cls_o = (funct3_i == UNIT_WIDTH) ? VC_LOAD : VC_ILLEGAL;
        end else if (opcode_i == OPC_VSTORE) begin
            cls_o = (funct3_i == UNIT_WIDTH) ? VC_STORE : VC_ILLEGAL;
        end else begin
            cls_o = VC_ILLEGAL;
        end
    end
endmodule

// File: rtl/vdec_extract.sv
// Module: slices the fields belonging to the given class out of the word and
// zeroes every field that class does not use. Assumes bits 6:0 are decoded
// elsewhere, so only bits 31:7 enter here.
module vdec_extract
    import vdec_pkg::*;
(
    input  logic [ILEN-1:POS_RD] body_i,
    input  vclass_e              cls_i,
    output vdec_bundle_t         bun_o
);
    logic [NCLASS-1:0] flag_w;

    // One flag per non-empty class, flag k-1 for class code k
    for (genvar k = 1; k <= NCLASS; k++) begin : g_flag
        assign flag_w[k-1] = (cls_i == vclass_e'(k));
    end

    // Field steering per class; unused fields stay zero
    always_comb begin
        bun_o       = '0;
        bun_o.flags = flag_w;
        unique case (cls_i)
            VC_CFG: begin
                bun_o.vd     = body_i[POS_RD +: REG_W];
                bun_o.rs1    = body_i[POS_RS1 +: REG_W];
                bun_o.funct3 = body_i[POS_F3 +: F3_W];
                if (!body_i[POS_FORM]) begin
                    bun_o.imm_form = 1'b1;
                    bun_o.imm      = body_i[POS_CIMM +: CIMM_W];
                end else begin
                    bun_o.rs2 = body_i[POS_RS2 +: REG_W];
                end
            end
            VC_ARITH: begin
                bun_o.vd     = body_i[POS_RD +: REG_W];
                bun_o.rs1    = body_i[POS_RS1 +: REG_W];
                bun_o.rs2    = body_i[POS_RS2 +: REG_W];
                bun_o.funct3 = body_i[POS_F3 +: F3_W];
                bun_o.funct6 = body_i[POS_F6 +: F6_W];
                bun_o.vm     = body_i[POS_VM];
            end
            VC_LOAD, VC_STORE: begin
                if (cls_i == VC_LOAD) bun_o.vd  = body_i[POS_RD +: REG_W];
                else                  bun_o.vs3 = body_i[POS_RD +: REG_W];
                bun_o.rs1    = body_i[POS_RS1 +: REG_W];
                bun_o.rs2    = body_i[POS_RS2 +: REG_W];
                bun_o.funct3 = body_i[POS_F3 +: F3_W];
                bun_o.vm     = body_i[POS_VM];
                bun_o.mop    = body_i[POS_MOP +: MOP_W];
                bun_o.nf     = body_i[POS_NF +: NF_W];
            end
            default: begin
                bun_o.vd = '0;
            end
        endcase
    end
endmodule

// File: rtl/vdec_outreg.sv
// Module: output stage holding the decoded bundle and its valid for one cycle.
// Assumes synchronous active-low reset clearing everything.
module vdec_outreg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         vld_i,
    input  logic [W-1:0] d_i,
    output logic         vld_o,
    output logic [W-1:0] q_o
);
    // Capture bundle and valid each cycle; clear on reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_o <= 1'b0;
            q_o   <= '0;
        end else begin
            vld_o <= vld_i;
            q_o   <= d_i;
        end
    end
endmodule

// File: rtl/vinsn_field_decoder.sv
// Module: top of the vector instruction field decoder. Classifies the word,
// steers its fields and registers the bundle, so results appear one cycle
// after the strobe. Assumes one word per cycle at most and no back-pressure.
module vinsn_field_decoder
    import vdec_pkg::*;
#(
    parameter logic [OPC_W-1:0] OPC_VARITH = 7'h57,
    parameter logic [OPC_W-1:0] OPC_VLOAD  = 7'h07,
    parameter logic [OPC_W-1:0] OPC_VSTORE = 7'h27,
    parameter logic [F3_W-1:0]  UNIT_WIDTH = 3'd6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ILEN-1:0]   insn_i,
    input  logic              insn_vld_i,
    output logic              dec_vld_o,
    output logic              dec_illegal_o,
    output logic              dec_is_cfg_o,
    output logic              dec_is_arith_o,
    output logic              dec_is_load_o,
    output logic              dec_is_store_o,
    output logic [REG_W-1:0]  dec_vd_o,
    output logic [REG_W-1:0]  dec_vs3_o,
    output logic [REG_W-1:0]  dec_rs1_o,
    output logic [REG_W-1:0]  dec_rs2_o,
    output logic [F3_W-1:0]   dec_funct3_o,
    output logic [F6_W-1:0]   dec_funct6_o,
    output logic              dec_vm_o,
    output logic [MOP_W-1:0]  dec_mop_o,
    output logic [NF_W-1:0]   dec_nf_o,
    output logic              dec_cfg_imm_form_o,
    output logic [CIMM_W-1:0] dec_cfg_imm_o
);
    localparam int BW = $bits(vdec_bundle_t);

    vclass_e      cls_w;
    vdec_bundle_t bun_w;
    vdec_bundle_t bun_q;
    logic [BW-1:0] bun_bits_q;

    vdec_classify #(
        .OPC_VARITH (OPC_VARITH),
        .OPC_VLOAD  (OPC_VLOAD),
        .OPC_VSTORE (OPC_VSTORE),
        .CFG_F3     (3'd7),
        .UNIT_WIDTH (UNIT_WIDTH)
    ) u_cls (
        .vld_i    (insn_vld_i),
        .opcode_i (insn_i[OPC_W-1:0]),
        .funct3_i (insn_i[POS_F3 +: F3_W]),
        .cls_o    (cls_w)
    );

    vdec_extract u_ext (
        .body_i (insn_i[ILEN-1:POS_RD]),
        .cls_i  (cls_w),
        .bun_o  (bun_w)
    );

    vdec_outreg #(.W(BW)) u_reg (
        .clk   (clk),
        .rst_n (rst_n),
        .vld_i (insn_vld_i),
        .d_i   (bun_w),
        .vld_o (dec_vld_o),
        .q_o   (bun_bits_q)
    );

    // Unpack the registered bundle onto the ports
    assign bun_q              = vdec_bundle_t'(bun_bits_q);
    assign dec_illegal_o      = bun_q.flags[4];
    assign dec_is_cfg_o       = bun_q.flags[3];
    assign dec_is_arith_o     = bun_q.flags[2];
    assign dec_is_load_o      = bun_q.flags[1];
    assign dec_is_store_o     = bun_q.flags[0];
    assign dec_vd_o           = bun_q.vd;
    assign dec_vs3_o          = bun_q.vs3;
    assign dec_rs1_o          = bun_q.rs1;
    assign dec_rs2_o          = bun_q.rs2;
    assign dec_funct3_o       = bun_q.funct3;
    assign dec_funct6_o       = bun_q.funct6;
    assign dec_vm_o           = bun_q.vm;
    assign dec_mop_o          = bun_q.mop;
    assign dec_nf_o           = bun_q.nf;
    assign dec_cfg_imm_form_o = bun_q.imm_form;
    assign dec_cfg_imm_o      = bun_q.imm;
endmodule

// File: rtl/vdec_checker.sv
// Module: property checker for the decoder, bound to the top. Observes ports
// only and relates the outputs to the word seen one edge earlier.
module vdec_checker #(
    parameter logic [6:0] OPC_VLOAD = 7'h07
) (
    input logic        clk,
    input logic        rst_n,
    input logic [31:0] insn_i,
    input logic        insn_vld_i,
    input logic        dec_vld_o,
    input logic        dec_illegal_o,
    input logic        dec_is_cfg_o,
    input logic        dec_is_arith_o,
    input logic        dec_is_load_o,
    input logic        dec_is_store_o,
    input logic [4:0]  dec_vd_o,
    input logic [4:0]  dec_vs3_o,
    input logic [4:0]  dec_rs1_o,
    input logic [4:0]  dec_rs2_o,
    input logic [2:0]  dec_funct3_o,
    input logic [5:0]  dec_funct6_o,
    input logic        dec_vm_o,
    input logic [2:0]  dec_mop_o,
    input logic [2:0]  dec_nf_o,
    input logic        dec_cfg_imm_form_o,
    input logic [10:0] dec_cfg_imm_o
);
    logic [4:0]  flags_w;
    logic [47:0] fields_w;
    assign flags_w  = {dec_illegal_o, dec_is_cfg_o, dec_is_arith_o, dec_is_load_o, dec_is_store_o};
    assign fields_w = {dec_vd_o, dec_vs3_o, dec_rs1_o, dec_rs2_o, dec_funct3_o, dec_funct6_o,
                       dec_vm_o, dec_mop_o, dec_nf_o, dec_cfg_imm_form_o, dec_cfg_imm_o};

    AST_VLD_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        insn_vld_i |=> dec_vld_o); // R1
    AST_VLD_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        !insn_vld_i |=> !dec_vld_o); // R1
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !dec_vld_o |-> (flags_w == '0 && fields_w == '0)); // R1
    AST_CFG_F3: assert property (@(posedge clk) disable iff (!rst_n)
        dec_is_cfg_o |-> dec_funct3_o == 3'd7); // R2
    AST_CFG_IMM_FORM: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_is_cfg_o && dec_cfg_imm_form_o) |-> dec_rs2_o == 5'd0); // R3
    AST_CFG_REG_FORM: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_is_cfg_o && !dec_cfg_imm_form_o) |-> dec_cfg_imm_o == 11'd0); // R4
    AST_ARITH_FIELDS: assert property (@(posedge clk) disable iff (!rst_n)
        dec_is_arith_o |-> {dec_funct6_o, dec_vm_o, dec_rs2_o, dec_rs1_o, dec_funct3_o, dec_vd_o}
                           == $past(insn_i[31:7])); // R5
    AST_LOAD_OPCODE: assert property (@(posedge clk) disable iff (!rst_n)
        dec_is_load_o |-> $past(insn_i[6:0]) == OPC_VLOAD); // R6
    AST_STORE_NO_VD: assert property (@(posedge clk) disable iff (!rst_n)
        dec_is_store_o |-> dec_vd_o == 5'd0); // R7
    AST_ILLEGAL_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        dec_illegal_o |-> fields_w == '0); // R8
    AST_ONE_CLASS: assert property (@(posedge clk) disable iff (!rst_n)
        dec_vld_o |-> $countones(flags_w) == 1); // R9
endmodule

bind vinsn_field_decoder vdec_checker #(.OPC_VLOAD(OPC_VLOAD)) u_chk (
    .clk(clk), .rst_n(rst_n), .insn_i(insn_i), .insn_vld_i(insn_vld_i),
    .dec_vld_o(dec_vld_o), .dec_illegal_o(dec_illegal_o), .dec_is_cfg_o(dec_is_cfg_o),
    .dec_is_arith_o(dec_is_arith_o), .dec_is_load_o(dec_is_load_o),
    .dec_is_store_o(dec_is_store_o), .dec_vd_o(dec_vd_o), .dec_vs3_o(dec_vs3_o),
    .dec_rs1_o(dec_rs1_o), .dec_rs2_o(dec_rs2_o), .dec_funct3_o(dec_funct3_o),
    .dec_funct6_o(dec_funct6_o), .dec_vm_o(dec_vm_o), .dec_mop_o(dec_mop_o),
    .dec_nf_o(dec_nf_o), .dec_cfg_imm_form_o(dec_cfg_imm_form_o), .dec_cfg_imm_o(dec_cfg_imm_o)
);

// File: tb/vinsn_field_decoder_test.sv
`timescale 1ns/1ps
module vinsn_field_decoder_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] insn = '0;
    logic        insn_vld = 1'b0;
    logic        d_vld, d_ill, d_cfg, d_ari, d_ld, d_st, d_vm, d_form;
    logic [4:0]  d_vd, d_vs3, d_rs1, d_rs2;
    logic [2:0]  d_f3, d_mop, d_nf;
    logic [5:0]  d_f6;
    logic [10:0] d_imm;
    int errors = 0;
    int checks = 0;

    always #4 clk = ~clk;

    vinsn_field_decoder uut (
        .clk(clk), .rst_n(rst_n), .insn_i(insn), .insn_vld_i(insn_vld),
        .dec_vld_o(d_vld), .dec_illegal_o(d_ill), .dec_is_cfg_o(d_cfg),
        .dec_is_arith_o(d_ari), .dec_is_load_o(d_ld), .dec_is_store_o(d_st),
        .dec_vd_o(d_vd), .dec_vs3_o(d_vs3), .dec_rs1_o(d_rs1), .dec_rs2_o(d_rs2),
        .dec_funct3_o(d_f3), .dec_funct6_o(d_f6), .dec_vm_o(d_vm), .dec_mop_o(d_mop),
        .dec_nf_o(d_nf), .dec_cfg_imm_form_o(d_form), .dec_cfg_imm_o(d_imm)
    );

    // Observed bundle: valid, flags (ill,cfg,arith,load,store), then fields
    function automatic logic [53:0] observed();
        return {d_vld, d_ill, d_cfg, d_ari, d_ld, d_st, d_vd, d_vs3, d_rs1, d_rs2,
                d_f3, d_f6, d_vm, d_mop, d_nf, d_form, d_imm};
    endfunction

    // Expected bundle computed from the requirements
    function automatic logic [53:0] expect_of(logic [31:0] w, logic v);
        logic [4:0] fl; logic [4:0] vd, vs3, rs1, rs2; logic [2:0] f3, mop, nf;
        logic [5:0] f6; logic vm, form; logic [10:0] imm;
        fl = 0; vd = 0; vs3 = 0; rs1 = 0; rs2 = 0; f3 = 0; mop = 0; nf = 0;
        f6 = 0; vm = 0; form = 0; imm = 0;
        if (v) begin
            if (w[6:0] == 7'h57 && w[14:12] == 3'd7) begin
                fl = 5'b01000; vd = w[11:7]; rs1 = w[19:15]; f3 = 3'd7;
                if (!w[31]) begin form = 1'b1; imm = w[30:20]; end
                else rs2 = w[24:20];
            end else if (w[6:0] == 7'h57) begin
                fl = 5'b00100; vd = w[11:7]; rs1 = w[19:15]; rs2 = w[24:20];
                f3 = w[14:12]; f6 = w[31:26]; vm = w[25];
            end else if ((w[6:0] == 7'h07 || w[6:0] == 7'h27) && w[14:12] == 3'd6) begin
                if (w[6:0] == 7'h07) begin fl = 5'b00010; vd = w[11:7]; end
                else begin fl = 5'b00001; vs3 = w[11:7]; end
                rs1 = w[19:15]; rs2 = w[24:20]; f3 = 3'd6; vm = w[25];
                mop = w[28:26]; nf = w[31:29];
            end else begin
                fl = 5'b10000;
            end
        end
        return {v, fl, vd, vs3, rs1, rs2, f3, f6, vm, mop, nf, form, imm};
    endfunction

    function automatic string tag_of(logic [53:0] e);
        if (!e[53]) return "R1";
        if (e[52]) return "R8";
        if (e[51]) return e[11] ? "R3" : "R4";
        if (e[50]) return "R5";
        if (e[49]) return "R6";
        return "R7";
    endfunction

    task automatic compare(string tag, logic [53:0] exp);
        logic [53:0] got;
        got = observed();
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s insn=%h got=%h exp=%h", tag, insn, got, exp);
        end
    endtask

    // Drive at a falling edge, let one rising edge pass, check at next falling edge
    task automatic apply(logic [31:0] w, logic v, string tag);
        insn = w; insn_vld = v;
        @(posedge clk); @(negedge clk);
        compare(tag, expect_of(w, v));
    endtask

    function automatic logic [31:0] enc(logic [2:0] nf, logic [2:0] mop, logic vm,
        logic [4:0] rs2, logic [4:0] rs1, logic [2:0] f3, logic [4:0] rd, logic [6:0] op);
        return {nf, mop, vm, rs2, rs1, f3, rd, op};
    endfunction

    initial begin : watchdog
        #(8 * 200000);
        errors++;
        $display("FAIL watchdog expired");
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin : main
        logic [53:0] e;
        void'($urandom(32'd20240611));
        insn = enc(3'd1, 3'd2, 1'b1, 5'd3, 5'd4, 3'd6, 5'd5, 7'h07);
        insn_vld = 1'b1;
        repeat (3) @(negedge clk);
        compare("R9 reset", 54'd0);
        rst_n = 1'b1;

        // R3: immediate form, imm 0x0D2
        apply({1'b0, 11'h0D2, 5'd10, 3'd7, 5'd5, 7'h57}, 1'b1, "R3");
        checks++;
        if (!(d_cfg && d_form && d_imm == 11'h0D2 && d_rs2 == 0 && d_vd == 5'd5)) begin
            errors++; $display("FAIL R3 cfg=%b form=%b imm=%h exp 1 1 0d2", d_cfg, d_form, d_imm);
        end
        // R4: register form
        apply({1'b1, 6'h15, 5'd17, 5'd9, 3'd7, 5'd2, 7'h57}, 1'b1, "R4");
        // R5 / R2: func3 0, func6 0, mask set
        apply(enc(3'd0, 3'd0, 1'b1, 5'd2, 5'd1, 3'd0, 5'd3, 7'h57), 1'b1, "R5");
        // R2: func3 3 and 6 are arithmetic, not configuration
        apply({6'b011000, 1'b0, 5'd7, 5'd8, 3'd3, 5'd9, 7'h57}, 1'b1, "R2");
        checks++;
        if (!d_ari || d_cfg) begin
            errors++; $display("FAIL R2 arith=%b cfg=%b exp 1 0", d_ari, d_cfg);
        end
        apply({6'b111111, 1'b1, 5'd31, 5'd31, 3'd6, 5'd31, 7'h57}, 1'b1, "R2");
        // R6: load with nonzero mode and field count
        apply(enc(3'd5, 3'd3, 1'b0, 5'd6, 5'd11, 3'd6, 5'd12, 7'h07), 1'b1, "R6");
        // R8: load with width 2
        apply(enc(3'd5, 3'd3, 1'b0, 5'd6, 5'd11, 3'd2, 5'd12, 7'h07), 1'b1, "R8");
        // R7: store, data register in bits 11:7
        apply(enc(3'd2, 3'd1, 1'b1, 5'd4, 5'd13, 3'd6, 5'd21, 7'h27), 1'b1, "R7");
        checks++;
        if (d_vs3 != 5'd21 || d_vd != 5'd0) begin
            errors++; $display("FAIL R7 vs3=%0d vd=%0d exp 21 0", d_vs3, d_vd);
        end
        // R8: store width 7, scalar opcode
        apply(enc(3'd2, 3'd1, 1'b1, 5'd4, 5'd13, 3'd7, 5'd21, 7'h27), 1'b1, "R8");
        apply(32'h00B50533, 1'b1, "R8");
        // R1: strobe low with a legal word present
        apply(enc(3'd1, 3'd1, 1'b1, 5'd1, 5'd1, 3'd6, 5'd1, 7'h07), 1'b0, "R1");
        // R1: back to back words, each one cycle later
        apply(enc(3'd0, 3'd0, 1'b0, 5'd1, 5'd2, 3'd6, 5'd3, 7'h27), 1'b1, "R1");
        apply(enc(3'd0, 3'd0, 1'b0, 5'd4, 5'd5, 3'd1, 5'd6, 7'h57), 1'b1, "R1");

        // Random mix
        for (int i = 0; i < 400; i++) begin
            logic [31:0] w;
            logic v;
            int sel;
            w = $urandom;
            sel = $urandom % 8;
            if (sel < 3)      w[6:0] = 7'h57;
            else if (sel < 5) w[6:0] = 7'h07;
            else if (sel < 7) w[6:0] = 7'h27;
            if (sel >= 3 && sel < 7 && ($urandom % 4) != 0) w[14:12] = 3'd6;
            if (sel < 2 && ($urandom % 2) == 0) w[14:12] = 3'd7;
            v = ($urandom % 6) != 0;
            e = expect_of(w, v);
            apply(w, v, tag_of(e));
            checks++;
            if (d_vld && $countones({d_ill, d_cfg, d_ari, d_ld, d_st}) != 1) begin
                errors++; $display("FAIL R9 flags=%b exp one hot",
                                   {d_ill, d_cfg, d_ari, d_ld, d_st});
            end
        end

        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule